// File: doc/BRIEF.md
# Double-Buffered Crosspoint Route Register Bank

This block is the parallel programming port of an eight-source, four-destination crosspoint router. A host presents a two-bit destination address and a four-bit route code on a parallel bus. The top code bit turns the addressed destination off. When that bit is clear, the three low bits name the source channel. Each destination owns two level-sensitive register stages in series. The first, the staging stage, is written one destination at a time. The second, the active stage, drives the route outputs, and one global commit control opens all four active stages together. Several destinations can therefore be staged first and then switched in the same cycle.

Each stage is transparent while its control is low and holds while its control is high. The behaviour is built on a fast system clock: the three active-low bus controls pass through a synchronizer, and an open stage reloads on every clock edge. Reset puts both stages into the off code, so every destination starts disabled and a commit issued before any write keeps them disabled. A shutdown input turns off every enable at once. Both stages keep accepting writes while shutdown is high, so the router can be reprogrammed during shutdown and come back in a new configuration.

Top module: `xpt_ctrl_bank`

## Requirements
- R1: While `bus_en_n` and `wr_n` are both low (after synchronization), only the staging stage selected by `addr` (0 to 3 selects destination 0 to 3) loads `data`. The other three staging stages keep their values.
- R2: While `bus_en_n` or `wr_n` is high, no staging stage changes, whatever `addr` and `data` carry.
- R3: While `commit_n` is high, the active stages hold, and `route_en`/`route_sel` do not change even after new codes are staged.
- R4: While `commit_n` is low, every active stage copies its staging stage, so destinations staged separately all switch in the same cycle.
- R5: With `bus_en_n`, `wr_n` and `commit_n` all low, the addressed destination follows the live `data` word. The other destinations keep showing their previously staged codes.
- R6: A code with bit 3 set drives `route_en` low for its destination. A code with bit 3 clear drives `route_en` high and places bits 2..0 on that destination's 3-bit field of `route_sel` (destination d at bits 3d+2..3d).
- R7: After reset, both stages of every destination hold the off code. `route_en` is all zero, and a commit issued before any write leaves it all zero.
- R8: While `shutdown` is high, `route_en` is all zero in the same cycle, and writes and commits still update both stages. When `shutdown` falls, the programmed routes appear.
- R9: Each control passes two synchronizer flops. A commit opened at one falling clock edge shows at the outputs after the third rising edge. A write made while commit is already open shows after the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en_n | input | 1 | Active-low bus enable for staging writes |
| wr_n | input | 1 | Active-low write strobe |
| commit_n | input | 1 | Active-low commit; opens all active stages |
| addr | input | 2 | Destination address |
| data | input | 4 | Route code: bit 3 off, bits 2..0 source |
| shutdown | input | 1 | Forces all enables low |
| route_sel | output | 12 | Source select, 3 bits per destination |
| route_en | output | 4 | Enable per destination |

## Verification
Because of the two-flop synchronizer, a result has a fixed latency. A commit reaches the outputs after the third rising edge that follows the falling edge where it was driven. A write made while commit is open reaches them after the fourth. Shutdown acts combinationally within the same cycle. The bench drives every input on the falling edge and samples on a later falling edge. Its latency scenario checks the cycle just before the new value is due, where the old value must still show, and then the cycle where the new value must appear. Every other scenario holds its controls for four cycles and releases them for four more before it checks, so no result is sampled during the synchronizer delay.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int XP_OUTS   = 4;
  localparam int XP_INS    = 8;
  localparam int XP_ADDR_W = $clog2(XP_OUTS);
  localparam int XP_SRC_W  = $clog2(XP_INS);
  localparam int XP_CODE_W = XP_SRC_W + 1;

  typedef struct packed {
    logic                off;
    logic [XP_SRC_W-1:0] src;
  } xp_code_t;

  localparam xp_code_t XP_CODE_IDLE = '{off: 1'b1, src: '0};
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xpt_level_reg.sv
module xpt_level_reg #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (open) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/xpt_ctrl_bank.sv
module xpt_ctrl_bank
  import xpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_en_n,
  input  logic                         wr_n,
  input  logic                         commit_n,
  input  logic [XP_ADDR_W-1:0]         addr,
  input  logic [XP_CODE_W-1:0]         data,
  input  logic                         shutdown,
  output logic [XP_OUTS*XP_SRC_W-1:0]  route_sel,
  output logic [XP_OUTS-1:0]           route_en
);
  localparam logic [XP_CODE_W-1:0] IDLE_VEC = XP_CODE_IDLE;
  localparam int OFF_BIT = XP_CODE_W - 1;

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // control synchronizer: {bus enable, write, commit}
  logic [2:0] ctl_s;
  logic       wr_open;
  logic       commit_open;

  xpt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({bus_en_n, wr_n, commit_n}),
    .q     (ctl_s)
  );

  assign wr_open     = ~ctl_s[2] & ~ctl_s[1];
  assign commit_open = ~ctl_s[0];

  // destination decode
  logic [XP_OUTS-1:0] stage_open;

  always_comb begin
    stage_open = '0;
    if (wr_open) stage_open[addr] = 1'b1;
  end

  logic [XP_CODE_W-1:0] stg_q [XP_OUTS];
  logic [XP_CODE_W-1:0] act_q [XP_OUTS];

  for (genvar g = 0; g < XP_OUTS; g++) begin : g_dest
    xpt_level_reg #(.W(XP_CODE_W), .RST_VAL(IDLE_VEC)) u_stage (
      .clk   (clk),
      .rst_n (rst_i),
      .open  (stage_open[g]),
      .d     (data),
      .q     (stg_q[g])
    );

    xpt_level_reg #(.W(XP_CODE_W), .RST_VAL(IDLE_VEC)) u_active (
      .clk   (clk),
      .rst_n (rst_i),
      .open  (commit_open),
      .d     (stg_q[g]),
      .q     (act_q[g])
    );

    assign route_sel[g*XP_SRC_W +: XP_SRC_W] = act_q[g][XP_SRC_W-1:0];
    assign route_en[g] = ~act_q[g][OFF_BIT] & ~shutdown;

    // R2: staging holds while the bus enable or the write strobe is high
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_i)
      (ctl_s[2] | ctl_s[1]) |=> $stable(stg_q[g]));

    // R3: active stage holds while commit is high
    p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_i)
      ctl_s[0] |=> $stable(act_q[g]));

    // R4: active stage follows staging while commit is open
    p_active_follow_r4: assert property (@(posedge clk) disable iff (!rst_i)
      commit_open |=> (act_q[g] == $past(stg_q[g])));

    // R6: an off code never drives an enable
    p_off_code_r6: assert property (@(posedge clk) disable iff (!rst_i)
      act_q[g][OFF_BIT] |-> !route_en[g]);
  end

  // R8: shutdown clears every enable
  p_shutdown_r8: assert property (@(posedge clk) disable iff (!rst_i)
    shutdown |-> (route_en == '0));
endmodule

// File: tb/tb_xpt_ctrl_bank.sv
module tb_xpt_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en_n, wr_n, commit_n, shutdown;
  logic [1:0]  addr;
  logic [3:0]  data;
  logic [11:0] route_sel;
  logic [3:0]  route_en;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xpt_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .wr_n(wr_n),
    .commit_n(commit_n), .addr(addr), .data(data), .shutdown(shutdown),
    .route_sel(route_sel), .route_en(route_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_dest(input string req, input int d, input bit en, input int sel);
    check({req, " enable"}, int'(route_en[d]), int'(en));
    if (en) check({req, " select"}, int'(route_sel[d*3 +: 3]), sel);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; data = d; bus_en_n = 1'b0; wr_n = 1'b0;
    idle(4);
    bus_en_n = 1'b1; wr_n = 1'b1;
    idle(4);
  endtask

  task automatic commit_pulse();
    @(negedge clk);
    commit_n = 1'b0;
    idle(4);
    commit_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset_state();
    check("R7 enables after reset", int'(route_en), 0);
    commit_pulse();
    check("R7 enables after early commit", int'(route_en), 0);
  endtask

  task automatic t_single_route();
    stage_write(2'd1, 4'b0101);
    check_dest("R3 staged but not committed", 1, 1'b0, 0);
    commit_pulse();
    check_dest("R6 dest1 routed", 1, 1'b1, 5);
  endtask

  task automatic t_simultaneous();
    stage_write(2'd0, 4'b0011);
    stage_write(2'd2, 4'b0111);
    stage_write(2'd3, 4'b0000);
    check("R3 outputs held before commit", int'(route_en), 4'b0010);
    commit_pulse();
    check_dest("R4 dest0", 0, 1'b1, 3);
    check_dest("R4 dest2", 2, 1'b1, 7);
    check_dest("R4 dest3", 3, 1'b1, 0);
    check_dest("R1 dest1 untouched", 1, 1'b1, 5);
  endtask

  task automatic t_strobe_gating();
    @(negedge clk);
    addr = 2'd2; data = 4'b0001; bus_en_n = 1'b1; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1; bus_en_n = 1'b0;
    idle(4);
    bus_en_n = 1'b1;
    idle(4);
    commit_pulse();
    check_dest("R2 dest2 unchanged", 2, 1'b1, 7);
  endtask

  task automatic t_disable_code();
    stage_write(2'd2, 4'b1011);
    commit_pulse();
    check_dest("R6 dest2 disabled", 2, 1'b0, 0);
    stage_write(2'd2, 4'b0100);
    commit_pulse();
    check_dest("R6 dest2 re-enabled", 2, 1'b1, 4);
  endtask

  task automatic t_commit_latency();
    stage_write(2'd1, 4'b0010);
    check_dest("R3 dest1 held", 1, 1'b1, 5);
    @(negedge clk);
    commit_n = 1'b0;
    idle(2);
    check_dest("R9 dest1 before third edge", 1, 1'b1, 5);
    idle(1);
    check_dest("R9 dest1 after third edge", 1, 1'b1, 2);
    commit_n = 1'b1;
    idle(4);
  endtask

  task automatic t_transparent();
    @(negedge clk);
    commit_n = 1'b0;
    idle(4);
    addr = 2'd3; data = 4'b0010; bus_en_n = 1'b0; wr_n = 1'b0;
    idle(3);
    check_dest("R9 write before fourth edge", 3, 1'b1, 0);
    idle(1);
    check_dest("R5 dest3 follows data", 3, 1'b1, 2);
    data = 4'b0110;
    idle(4);
    check_dest("R5 dest3 follows new data", 3, 1'b1, 6);
    check_dest("R5 dest0 keeps stored", 0, 1'b1, 3);
    bus_en_n = 1'b1; wr_n = 1'b1;
    idle(4);
    commit_n = 1'b1;
    idle(4);
  endtask

  task automatic t_shutdown();
    @(negedge clk);
    shutdown = 1'b1;
    #1;
    check("R8 enables off in shutdown", int'(route_en), 0);
    stage_write(2'd0, 4'b0001);
    commit_pulse();
    check("R8 still off after commit", int'(route_en), 0);
    @(negedge clk);
    shutdown = 1'b0;
    #1;
    check_dest("R8 dest0 reprogrammed", 0, 1'b1, 1);
    check_dest("R8 dest1", 1, 1'b1, 2);
    check_dest("R8 dest2", 2, 1'b1, 4);
    check_dest("R8 dest3", 3, 1'b1, 6);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_en_n = 1'b1; wr_n = 1'b1; commit_n = 1'b1;
    shutdown = 1'b0; addr = 2'd0; data = 4'd0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    t_reset_state();
    t_single_route();
    t_simultaneous();
    t_strobe_gating();
    t_disable_code();
    t_commit_latency();
    t_transparent();
    t_shutdown();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule